// File: doc/BRIEF.md
# Virtualized Supervisor Timer-Compare Unit

This block keeps two 64-bit timer-compare registers next to a hart's CSR file. One belongs to the supervisor. The other belongs to a guest supervisor running under a hypervisor. Each register is compared against a free-running 64-bit time value. For the guest, the hypervisor's 64-bit time offset is added to the time value before the comparison. The result of each comparison is a timer-pending output.

The CSR file forwards each access to the block as one cycle on the access port. An access carries an address, a write flag, write data, the current privilege level, the virtualization-mode flag and a 32-bit/64-bit mode select. The block returns read data and a fault code in the same cycle. A permitted write takes effect at the next clock edge.

While virtualization mode is on, the supervisor compare addresses are redirected to the guest register. Guest accesses go through a two-stage permission check: the machine-level enables first, then the hypervisor-level enables. The block also forms the interrupt-pending word. That word adds the guest timer bit and the selected guest external-interrupt bit to the software pending word, then masks the result with the interrupt-enable word.

Top module: `vtcmp_unit`

## Requirements
- R1: A synchronous active-high reset clears both compare registers to zero.
- R2: The supervisor compare register sits at 0x14D, with its upper half at 0x15D. The guest compare register sits at 0x24D, with its upper half at 0x25D. Any other address returns fault 0 and read data 0, and changes no register.
- R3: In 64-bit mode (`acc_xl32_i`=0), the low address reads and writes all 64 bits. An access to either upper-half address in 64-bit mode is an illegal-instruction fault.
- R4: In 32-bit mode, a write to a low address replaces bits 31:0 and keeps bits 63:32. A write to an upper address replaces bits 63:32 with write data 31:0 and keeps bits 31:0. Reads return the addressed half, zero-extended.
- R5: While `acc_virt_i`=1, reads and writes to 0x14D and 0x15D act on the guest register instead of the supervisor register.
- R6: The fault code is 0 for none, 1 for illegal instruction and 2 for virtual instruction. If the extension is disabled (`ext_en_i`=0) or no time source is present (`tsrc_ok_i`=0), every access to the four addresses gives code 1.
- R7: At machine privilege (`acc_priv_i`=3), accesses to either register are permitted, apart from the cases named in R3 and R6.
- R8: Below machine privilege, an access gives code 1 unless both machine enables (counter-enable timer bit and environment timer-compare enable) are set. If that check passes and the access targets the guest register, it gives code 2 unless both hypervisor enables are set.
- R9: A faulting access changes neither register and returns read data 0.
- R10: `stip_o` is 1 exactly when time is greater than or equal to the supervisor compare value, unsigned. `vstip_o` is 1 exactly when (time + offset) mod 2^64 is greater than or equal to the guest compare value, unsigned. Both follow the register contents in the cycle after a write, so a write that moves a compare value into the future clears the bit one cycle later.
- R11: `irq_pend_o` equals (`pend_word_i` OR `vstip_o` at bit 6 OR the selected guest external bit at bit 10) AND `ie_i`. The selected guest external bit is `geip_i[vgein_i]` when 1 <= `vgein_i` < 8, and 0 otherwise. A 0 at bit 6 of `pend_word_i` never masks a set guest timer bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | 64 | Free-running time value |
| toffs_i | input | 64 | Hypervisor time offset for the guest timer |
| ext_en_i | input | 1 | Timer-compare extension enabled |
| tsrc_ok_i | input | 1 | Time source present |
| m_cnt_tm_i | input | 1 | Machine counter-enable timer bit |
| m_env_ce_i | input | 1 | Machine environment timer-compare enable |
| h_cnt_tm_i | input | 1 | Hypervisor counter-enable timer bit |
| h_env_ce_i | input | 1 | Hypervisor environment timer-compare enable |
| acc_valid_i | input | 1 | CSR access present this cycle |
| acc_we_i | input | 1 | Access is a write |
| acc_addr_i | input | 12 | CSR address |
| acc_wdata_i | input | 64 | Write data |
| acc_priv_i | input | 2 | Privilege level (0 user, 1 supervisor, 3 machine) |
| acc_virt_i | input | 1 | Virtualization mode active |
| acc_xl32_i | input | 1 | 1 selects 32-bit mode |
| acc_rdata_o | output | 64 | Read data |
| acc_fault_o | output | 2 | Fault code (0 none, 1 illegal, 2 virtual) |
| pend_word_i | input | 64 | Software interrupt-pending word |
| ie_i | input | 64 | Interrupt-enable word |
| geip_i | input | 8 | Guest external-interrupt lines |
| vgein_i | input | 6 | Guest external-interrupt selector |
| stip_o | output | 1 | Supervisor timer pending |
| vstip_o | output | 1 | Guest timer pending |
| irq_pend_o | output | 64 | Combined, enabled interrupt-pending word |

## Verification
The assertions watch several properties on every cycle:
- A faulting access leaves both registers stable and returns zero.
- Addresses outside the four never fault.
- A disabled extension always gives the illegal code, and machine privilege never faults on a low address.
- A failed hypervisor-level check gives the virtual code.
- A 32-bit low write to the guest register keeps its upper half.
- A set guest timer bit reaches the enabled pending word.

Only the bench's sweeps can show that the full grid of address, privilege, mode and enable combinations gives the right codes and data. The same holds for the virtualization redirect landing in the guest register, and for the compare outputs switching exactly at the boundary, including when the offset addition wraps.

// File: rtl/vtcmp_pkg.sv
package vtcmp_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned TIME_W = 64;
    localparam int unsigned HALF_W = TIME_W / 2;

    localparam logic [ADDR_W-1:0] A_SUP_LO = 12'h14D;
    localparam logic [ADDR_W-1:0] A_SUP_HI = 12'h15D;
    localparam logic [ADDR_W-1:0] A_GST_LO = 12'h24D;
    localparam logic [ADDR_W-1:0] A_GST_HI = 12'h25D;

    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_ILL  = 2'd1,
        FLT_VIRT = 2'd2
    } fault_e;

    typedef struct packed {
        logic   hit;
        logic   guest;
        logic   hi;
        logic   xl32;
        fault_e fault;
    } acc_dec_t;

    typedef struct packed {
        logic full;
        logic lo;
        logic hi;
    } wr_sel_t;

    function automatic logic [TIME_W-1:0] pick_half(
        input logic [TIME_W-1:0] v,
        input logic              xl32,
        input logic              hi
    );
        logic [TIME_W-1:0] r;
        if (!xl32)
            r = v;
        else if (hi)
            r = {{HALF_W{1'b0}}, v[TIME_W-1:HALF_W]};
        else
            r = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
        return r;
    endfunction

endpackage

// File: rtl/vtcmp_access.sv
module vtcmp_access
    import vtcmp_pkg::*;
(
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              xl32_i,
    input  logic              ext_en_i,
    input  logic              tsrc_ok_i,
    input  logic              m_tm_i,
    input  logic              m_ce_i,
    input  logic              h_tm_i,
    input  logic              h_ce_i,
    output acc_dec_t          dec_o
);

    logic sup_lo, sup_hi, gst_lo, gst_hi;
    logic any_sup, any_gst;
    logic m_ok, h_ok;

    assign sup_lo  = (addr_i == A_SUP_LO);
    assign sup_hi  = (addr_i == A_SUP_HI);
    assign gst_lo  = (addr_i == A_GST_LO);
    assign gst_hi  = (addr_i == A_GST_HI);
    assign any_sup = sup_lo | sup_hi;
    assign any_gst = gst_lo | gst_hi;
    assign m_ok    = m_tm_i & m_ce_i;
    assign h_ok    = h_tm_i & h_ce_i;

    always_comb begin
        dec_o.hit   = valid_i & (any_sup | any_gst);
        dec_o.guest = any_gst | (any_sup & virt_i);
        dec_o.hi    = sup_hi | gst_hi;
        dec_o.xl32  = xl32_i;
        dec_o.fault = FLT_NONE;
        if (dec_o.hit) begin
            if (!ext_en_i || !tsrc_ok_i)
                dec_o.fault = FLT_ILL;
            else if (dec_o.hi && !xl32_i)
                dec_o.fault = FLT_ILL;
            else if (priv_i == PRIV_MACHINE)
                dec_o.fault = FLT_NONE;
            else if (!m_ok)
                dec_o.fault = FLT_ILL;
            else if (dec_o.guest && !h_ok)
                dec_o.fault = FLT_VIRT;
        end
    end

endmodule

// File: rtl/vtcmp_cmpreg.sv
module vtcmp_cmpreg #(
    parameter int unsigned W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  vtcmp_pkg::wr_sel_t   wsel_i,
    input  logic [W-1:0]         wdata_i,
    input  logic [W-1:0]         now_i,
    output logic [W-1:0]         cmp_o,
    output logic                 pend_o
);

    localparam int unsigned H = W / 2;

    logic [W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '0;
        else if (wsel_i.full)
            cmp_q <= wdata_i;
        else if (wsel_i.lo)
            cmp_q[H-1:0] <= wdata_i[H-1:0];
        else if (wsel_i.hi)
            cmp_q[W-1:H] <= wdata_i[H-1:0];
    end

    assign cmp_o  = cmp_q;
    assign pend_o = (now_i >= cmp_q);

endmodule

// File: rtl/vtcmp_irq.sv
module vtcmp_irq #(
    parameter int unsigned PW      = 64,
    parameter int unsigned GEIP_W  = 8,
    parameter int unsigned GEIN_W  = 6,
    parameter int unsigned VST_BIT = 6,
    parameter int unsigned VSE_BIT = 10
) (
    input  logic [PW-1:0]     pend_word_i,
    input  logic              vstip_i,
    input  logic [GEIP_W-1:0] geip_i,
    input  logic [GEIN_W-1:0] vgein_i,
    input  logic [PW-1:0]     ie_i,
    output logic [PW-1:0]     irq_o
);

    logic          vseip;
    logic [PW-1:0] inject;

    always_comb begin
        vseip = 1'b0;
        for (int k = 1; k < GEIP_W; k++) begin
            if (vgein_i == GEIN_W'(k))
                vseip = geip_i[k];
        end
    end

    always_comb begin
        inject          = '0;
        inject[VST_BIT] = vstip_i;
        inject[VSE_BIT] = vseip;
    end

    assign irq_o = (pend_word_i | inject) & ie_i;

endmodule

// File: rtl/vtcmp_unit.sv
module vtcmp_unit
    import vtcmp_pkg::*;
#(
    parameter int unsigned PW      = 64,
    parameter int unsigned GEIP_W  = 8,
    parameter int unsigned GEIN_W  = 6,
    parameter int unsigned VST_BIT = 6,
    parameter int unsigned VSE_BIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       time_i,
    input  logic [63:0]       toffs_i,
    input  logic              ext_en_i,
    input  logic              tsrc_ok_i,
    input  logic              m_cnt_tm_i,
    input  logic              m_env_ce_i,
    input  logic              h_cnt_tm_i,
    input  logic              h_env_ce_i,
    input  logic              acc_valid_i,
    input  logic              acc_we_i,
    input  logic [11:0]       acc_addr_i,
    input  logic [63:0]       acc_wdata_i,
    input  logic [1:0]        acc_priv_i,
    input  logic              acc_virt_i,
    input  logic              acc_xl32_i,
    output logic [63:0]       acc_rdata_o,
    output logic [1:0]        acc_fault_o,
    input  logic [PW-1:0]     pend_word_i,
    input  logic [PW-1:0]     ie_i,
    input  logic [GEIP_W-1:0] geip_i,
    input  logic [GEIN_W-1:0] vgein_i,
    output logic              stip_o,
    output logic              vstip_o,
    output logic [PW-1:0]     irq_pend_o
);

    localparam int unsigned NREG = 2;   // index 0 supervisor, 1 guest

    acc_dec_t         dec;
    logic             wr_ok;
    logic [TIME_W-1:0] now_v  [NREG];
    logic [TIME_W-1:0] cmp_v  [NREG];
    logic              pend_v [NREG];
    wr_sel_t           wsel_v [NREG];
    logic [TIME_W-1:0] sel_cmp;
    logic [TIME_W-1:0] s_cmp_w, g_cmp_w;

    vtcmp_access u_access (
        .valid_i   (acc_valid_i),
        .addr_i    (acc_addr_i),
        .priv_i    (acc_priv_i),
        .virt_i    (acc_virt_i),
        .xl32_i    (acc_xl32_i),
        .ext_en_i  (ext_en_i),
        .tsrc_ok_i (tsrc_ok_i),
        .m_tm_i    (m_cnt_tm_i),
        .m_ce_i    (m_env_ce_i),
        .h_tm_i    (h_cnt_tm_i),
        .h_ce_i    (h_env_ce_i),
        .dec_o     (dec)
    );

    assign wr_ok    = dec.hit & acc_we_i & (dec.fault == FLT_NONE);
    assign now_v[0] = time_i;
    assign now_v[1] = time_i + toffs_i;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic tgt;
        assign tgt = (i == 1) ? dec.guest : ~dec.guest;

        always_comb begin
            wsel_v[i].full = wr_ok & tgt & ~dec.xl32;
            wsel_v[i].lo   = wr_ok & tgt &  dec.xl32 & ~dec.hi;
            wsel_v[i].hi   = wr_ok & tgt &  dec.xl32 &  dec.hi;
        end

        vtcmp_cmpreg #(.W(TIME_W)) u_cmp (
            .clk     (clk),
            .rst     (rst),
            .wsel_i  (wsel_v[i]),
            .wdata_i (acc_wdata_i),
            .now_i   (now_v[i]),
            .cmp_o   (cmp_v[i]),
            .pend_o  (pend_v[i])
        );
    end

    assign s_cmp_w = cmp_v[0];
    assign g_cmp_w = cmp_v[1];
    assign sel_cmp = dec.guest ? g_cmp_w : s_cmp_w;

    always_comb begin
        acc_rdata_o = '0;
        if (dec.hit && dec.fault == FLT_NONE)
            acc_rdata_o = pick_half(sel_cmp, dec.xl32, dec.hi);
    end

    assign acc_fault_o = dec.fault;
    assign stip_o      = pend_v[0];
    assign vstip_o     = pend_v[1];

    vtcmp_irq #(
        .PW      (PW),
        .GEIP_W  (GEIP_W),
        .GEIN_W  (GEIN_W),
        .VST_BIT (VST_BIT),
        .VSE_BIT (VSE_BIT)
    ) u_irq (
        .pend_word_i (pend_word_i),
        .vstip_i     (pend_v[1]),
        .geip_i      (geip_i),
        .vgein_i     (vgein_i),
        .ie_i        (ie_i),
        .irq_o       (irq_pend_o)
    );

endmodule

// File: rtl/vtcmp_unit_chk.sv
module vtcmp_unit_chk
    import vtcmp_pkg::*;
#(
    parameter int unsigned PW      = 64,
    parameter int unsigned VST_BIT = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          ext_en_i,
    input logic          tsrc_ok_i,
    input logic          m_cnt_tm_i,
    input logic          m_env_ce_i,
    input logic          h_cnt_tm_i,
    input logic          h_env_ce_i,
    input logic          acc_valid_i,
    input logic          acc_we_i,
    input logic [11:0]   acc_addr_i,
    input logic [1:0]    acc_priv_i,
    input logic          acc_xl32_i,
    input logic [63:0]   acc_rdata_o,
    input logic [1:0]    acc_fault_o,
    input logic [PW-1:0] ie_i,
    input logic          vstip_o,
    input logic [PW-1:0] irq_pend_o,
    input logic [63:0]   s_cmp,
    input logic [63:0]   g_cmp
);

    logic known;
    assign known = (acc_addr_i == A_SUP_LO) || (acc_addr_i == A_SUP_HI) ||
                   (acc_addr_i == A_GST_LO) || (acc_addr_i == A_GST_HI);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (s_cmp == 64'd0 && g_cmp == 64'd0)); // R1

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && !known) |-> (acc_fault_o == 2'd0 && acc_rdata_o == 64'd0)); // R2

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && acc_we_i && acc_xl32_i && acc_addr_i == A_GST_LO && acc_fault_o == 2'd0)
        |=> (g_cmp[63:32] == $past(g_cmp[63:32]))); // R4

    AST_OFF_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && known && !(ext_en_i && tsrc_ok_i)) |-> (acc_fault_o == 2'd1)); // R6

    AST_MACHINE_OK: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && ext_en_i && tsrc_ok_i && acc_priv_i == PRIV_MACHINE &&
         (acc_addr_i == A_SUP_LO || acc_addr_i == A_GST_LO)) |-> (acc_fault_o == 2'd0)); // R7

    AST_VIRT_FAULT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && ext_en_i && tsrc_ok_i && acc_priv_i != PRIV_MACHINE &&
         acc_addr_i == A_GST_LO && m_cnt_tm_i && m_env_ce_i &&
         !(h_cnt_tm_i && h_env_ce_i)) |-> (acc_fault_o == 2'd2)); // R8

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && acc_fault_o != 2'd0) |=> ($stable(s_cmp) && $stable(g_cmp))); // R9

    AST_FAULT_ZERO_RD: assert property (@(posedge clk) disable iff (rst)
        (acc_fault_o != 2'd0) |-> (acc_rdata_o == 64'd0)); // R9

    AST_VSTIP_REACHES: assert property (@(posedge clk) disable iff (rst)
        (vstip_o && ie_i[VST_BIT]) |-> irq_pend_o[VST_BIT]); // R11

endmodule

bind vtcmp_unit vtcmp_unit_chk #(.PW(PW), .VST_BIT(VST_BIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_en_i    (ext_en_i),
    .tsrc_ok_i   (tsrc_ok_i),
    .m_cnt_tm_i  (m_cnt_tm_i),
    .m_env_ce_i  (m_env_ce_i),
    .h_cnt_tm_i  (h_cnt_tm_i),
    .h_env_ce_i  (h_env_ce_i),
    .acc_valid_i (acc_valid_i),
    .acc_we_i    (acc_we_i),
    .acc_addr_i  (acc_addr_i),
    .acc_priv_i  (acc_priv_i),
    .acc_xl32_i  (acc_xl32_i),
    .acc_rdata_o (acc_rdata_o),
    .acc_fault_o (acc_fault_o),
    .ie_i        (ie_i),
    .vstip_o     (vstip_o),
    .irq_pend_o  (irq_pend_o),
    .s_cmp       (s_cmp_w),
    .g_cmp       (g_cmp_w)
);

// File: tb/vtcmp_unit_bench.sv
`timescale 1ns/1ps
module vtcmp_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_i = '0, toffs_i = '0;
    logic        ext_en_i = 1'b1, tsrc_ok_i = 1'b1;
    logic        m_cnt_tm_i = 1'b1, m_env_ce_i = 1'b1, h_cnt_tm_i = 1'b1, h_env_ce_i = 1'b1;
    logic        acc_valid_i = 1'b0, acc_we_i = 1'b0;
    logic [11:0] acc_addr_i = '0;
    logic [63:0] acc_wdata_i = '0;
    logic [1:0]  acc_priv_i = 2'd3;
    logic        acc_virt_i = 1'b0, acc_xl32_i = 1'b0;
    logic [63:0] acc_rdata_o;
    logic [1:0]  acc_fault_o;
    logic [63:0] pend_word_i = '0, ie_i = '0;
    logic [7:0]  geip_i = '0;
    logic [5:0]  vgein_i = '0;
    logic        stip_o, vstip_o;
    logic [63:0] irq_pend_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] s_m = '0, g_m = '0;   // bench model of the two registers

    always #2.5 clk = ~clk;

    vtcmp_unit u_vtcmp_unit (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [11:0] a, input logic [1:0] pr,
                                             input logic v, input logic x);
        logic sup, gst, hi, tg;
        sup = (a == 12'h14D) || (a == 12'h15D);
        gst = (a == 12'h24D) || (a == 12'h25D);
        hi  = (a == 12'h15D) || (a == 12'h25D);
        tg  = gst || (sup && v);
        if (!(sup || gst)) return 2'd0;
        if (!ext_en_i || !tsrc_ok_i) return 2'd1;   // R6
        if (hi && !x) return 2'd1;                   // R3
        if (pr == 2'd3) return 2'd0;                 // R7
        if (!(m_cnt_tm_i && m_env_ce_i)) return 2'd1; // R8 stage one
        if (tg && !(h_cnt_tm_i && h_env_ce_i)) return 2'd2; // R8 stage two
        return 2'd0;
    endfunction

    task automatic acc(input logic [11:0] a, input logic we, input logic [63:0] wd,
                       input logic [1:0] pr, input logic v, input logic x);
        logic [1:0]  f;
        logic        known, tg, hi;
        logic [63:0] sel, er;
        @(negedge clk);
        acc_valid_i = 1'b1; acc_we_i = we; acc_addr_i = a; acc_wdata_i = wd;
        acc_priv_i = pr; acc_virt_i = v; acc_xl32_i = x;
        #1;
        known = (a == 12'h14D) || (a == 12'h15D) || (a == 12'h24D) || (a == 12'h25D);
        tg    = (a == 12'h24D) || (a == 12'h25D) || (((a == 12'h14D) || (a == 12'h15D)) && v);
        hi    = (a == 12'h15D) || (a == 12'h25D);
        f     = exp_fault(a, pr, v, x);
        sel   = tg ? g_m : s_m;
        if (!known || f != 2'd0) er = '0;                  // R2 R9
        else if (!x) er = sel;                             // R3 R5
        else if (hi) er = {32'd0, sel[63:32]};             // R4
        else er = {32'd0, sel[31:0]};
        chk("R6 R7 R8 fault code", {62'd0, acc_fault_o}, {62'd0, f});
        chk("R2 R3 R4 R5 R9 read data", acc_rdata_o, er);
        @(posedge clk);
        #1;
        acc_valid_i = 1'b0; acc_we_i = 1'b0;
        if (known && we && f == 2'd0) begin
            if (!x) begin
                if (tg) g_m = wd; else s_m = wd;
            end else if (hi) begin
                if (tg) g_m[63:32] = wd[31:0]; else s_m[63:32] = wd[31:0];
            end else begin
                if (tg) g_m[31:0] = wd[31:0]; else s_m[31:0] = wd[31:0];
            end
        end
    endtask

    task automatic chk_tmr(input string tag);
        #1;
        chk({tag, " R10 stip"}, {63'd0, stip_o}, {63'd0, (time_i >= s_m)});
        chk({tag, " R10 vstip"}, {63'd0, vstip_o}, {63'd0, ((time_i + toffs_i) >= g_m)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] alist [5];
        logic [1:0]  plist [3];
        int          n;
        alist[0] = 12'h14D; alist[1] = 12'h15D; alist[2] = 12'h24D;
        alist[3] = 12'h25D; alist[4] = 12'h123;
        plist[0] = 2'd0; plist[1] = 2'd1; plist[2] = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: both registers read zero after reset
        acc(12'h14D, 1'b0, '0, 2'd3, 1'b0, 1'b0);
        acc(12'h24D, 1'b0, '0, 2'd3, 1'b0, 1'b0);
        chk_tmr("R1 reset");

        // sweep of address x privilege x mode x enables
        n = 0;
        for (int ai = 0; ai < 5; ai++)
            for (int pi = 0; pi < 3; pi++)
                for (int v = 0; v < 2; v++)
                    for (int x = 0; x < 2; x++)
                        for (int en = 0; en < 64; en++) begin
                            m_cnt_tm_i = en[0]; m_env_ce_i = en[1];
                            h_cnt_tm_i = en[2]; h_env_ce_i = en[3];
                            ext_en_i   = ~en[4]; tsrc_ok_i = ~en[5];
                            n++;
                            acc(alist[ai], (n % 3) != 0,
                                {32'(n) * 32'h9E3779B9, 32'(n) * 32'h7F4A7C15},
                                plist[pi], v[0], x[0]);
                        end
        ext_en_i = 1; tsrc_ok_i = 1; m_cnt_tm_i = 1; m_env_ce_i = 1;
        h_cnt_tm_i = 1; h_env_ce_i = 1;

        // R10 boundaries, supervisor and guest with wrapping offset
        acc(12'h14D, 1'b1, 64'd1000, 2'd3, 1'b0, 1'b0);
        acc(12'h24D, 1'b1, 64'd5, 2'd3, 1'b0, 1'b0);
        toffs_i = 64'hFFFF_FFFF_FFFF_FFF6;   // -10
        for (int d = -2; d <= 2; d++) begin
            @(negedge clk);
            time_i = 64'(1000 + d);
            chk_tmr("R10 boundary");
            time_i = 64'(15 + d);            // guest sees 5+d
            chk_tmr("R10 wrap");
        end
        // compare near top of range, unsigned
        acc(12'h24D, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 2'd3, 1'b0, 1'b0);
        @(negedge clk); time_i = 64'd5; toffs_i = 64'hFFFF_FFFF_FFFF_FFF0;
        chk_tmr("R10 unsigned");
        // past compare then move into future: clears next cycle
        acc(12'h24D, 1'b1, 64'd0, 2'd3, 1'b0, 1'b0);
        chk_tmr("R10 past");
        acc(12'h24D, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b0);
        chk_tmr("R10 future");
        // 32-bit half write into the past via redirect (R5)
        acc(12'h15D, 1'b1, 64'd0, 2'd1, 1'b1, 1'b1);
        chk_tmr("R5 R10 redirect hi");

        // R11 interrupt merge
        for (int vs = 0; vs < 2; vs++) begin
            acc(12'h24D, 1'b1, vs ? 64'd0 : 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b0);
            for (int gi = 0; gi < 10; gi++)
                for (int gp = 0; gp < 2; gp++)
                    for (int ip = 0; ip < 2; ip++) begin
                        logic [63:0] ew;
                        logic        vse;
                        @(negedge clk);
                        vgein_i = 6'(gi);
                        geip_i  = gp ? 8'hAA : 8'h55;
                        ie_i    = ip ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_F0F0_0000_FBBF;
                        pend_word_i = 64'h1234_0000_0000_0022 ^ 64'(gi);
                        #1;
                        vse = (gi >= 1 && gi < 8) ? geip_i[gi] : 1'b0;
                        ew  = pend_word_i;
                        ew[6]  = ew[6] | vstip_o;
                        ew[10] = ew[10] | vse;
                        ew = ew & ie_i;
                        chk("R11 pending word", irq_pend_o, ew);
                        if (vs == 1) chk("R11 vstip set", {63'd0, vstip_o}, 64'd1);
                    end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule